// File: doc/BRIEF.md
# Four-Slot Word-Serial Descriptor Queue

This block is the per-channel descriptor queue of a DMA channel. Software builds each transfer descriptor by writing four 32-bit words, one after another, to a single load port. The words are the low half of the buffer address, the high half, the byte count and a flag word. The fourth word completes the descriptor and commits it to one of four slots. A transfer engine takes committed descriptors in order through a valid/ready port that presents the whole 128-bit descriptor in one cycle.

A read-only status word shows the raw write and read slot pointers, an empty flag, a full flag and a sticky error flag. The error flag is raised when a descriptor is completed while all four slots are taken. Software clears it by writing a one to its bit. A control bit holds the queue in reset. While the bit is set, the queue is empty and the load port is ignored. Any partly loaded descriptor is thrown away.

Top module: `desc_ring`

## Requirements
- R1: After `rst_n` is released, `status` reads 32'h0000_0100 (empty, both pointers 0, no error) and `out_valid` is 0.
- R2: `status` places the write pointer in bits [1:0], the read pointer in [5:4], empty in bit 8, full in bit 9 and error in bit 10; every other bit is 0. When the pointers are equal exactly one of empty/full is set; otherwise occupancy is (write − read) mod 4 and neither flag is set.
- R3: Load-port words are taken in the order address low, address high, byte count, flags. The consumer sees `out_addr` = {high, low}, `out_len` = count and `out_flags` = flags.
- R4: The first three words of a descriptor leave `status` and `out_valid` unchanged. The write pointer advances on the cycle after the fourth word.
- R5: `out_valid` is 1 exactly when the queue is not empty. A cycle with `out_valid` and `out_ready` both 1 removes the oldest descriptor and advances the read pointer by one, so descriptors leave in the order they were completed.
- R6: A fourth word arriving while the queue is full (as seen before that edge) discards that descriptor and sets the error flag. Pointers and stored descriptors are not changed.
- R7: The error flag stays set until a status write with bit 10 = 1. A status write with bit 10 = 0 leaves it set. A new overflow in the same cycle as a clear wins.
- R8: A control write with bit 0 = 1 empties the queue, zeroes both pointers and the error flag, and drops any partial descriptor. These take effect from the next cycle. Load-port words are ignored until a control write with bit 0 = 0. The next four words after that form a fresh descriptor.
- R9: `out_notify` equals bit 16 of the flags word of the descriptor being presented.
- R10: `out_ready` while `out_valid` is 0 has no effect on the pointers or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load-port word strobe |
| ld_data | input | 32 | Load-port word |
| stat_wr | input | 1 | Status write strobe (only bit 10 acts) |
| stat_wdata | input | 32 | Status write data |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 32 | Control write data; bit 0 holds the queue in reset |
| status | output | 32 | Pointers and flags |
| out_valid | output | 1 | A descriptor is offered |
| out_ready | input | 1 | Engine takes the offered descriptor |
| out_addr | output | 64 | Buffer address |
| out_len | output | 32 | Byte count |
| out_flags | output | 32 | Flag word |
| out_notify | output | 1 | Completion notification request |

## Verification
The bench runs rounds of one to four descriptors from every pointer position, so the pointers wrap through all values. It checks the status word after every completed descriptor and every pop against an arithmetic model. A design that confused full with empty when the pointers meet, or committed a descriptor early on a partial load, would show a wrong status word right away. Overflow is driven while full: a design that overwrote a slot or moved the write pointer would present a corrupt head descriptor or a shifted pointer. Error clearing with the wrong bit, ring reset with a partial descriptor pending, and pops while empty are each driven, and a stale word counter would shift the fields of the next descriptor.

// File: rtl/desc_ring.sv
module desc_ring #(
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld_en,
  input  logic [WORD_W-1:0]   ld_data,
  input  logic                stat_wr,
  input  logic [WORD_W-1:0]   stat_wdata,
  input  logic                ctl_wr,
  input  logic [WORD_W-1:0]   ctl_wdata,
  output logic [WORD_W-1:0]   status,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [2*WORD_W-1:0] out_addr,
  output logic [WORD_W-1:0]   out_len,
  output logic [WORD_W-1:0]   out_flags,
  output logic                out_notify
);
  localparam int SLOTS      = 4;
  localparam int PW         = $clog2(SLOTS);
  localparam int DESC_W     = 4 * WORD_W;
  localparam int NOTIFY_BIT = 16;

  logic              hold_rst;
  logic [1:0]        word_cnt;
  logic [WORD_W-1:0] stage [3];
  logic [DESC_W-1:0] slot [SLOTS];
  logic [PW-1:0]     wp, rp;
  logic [PW:0]       fill;
  logic              err;

  logic rst_now, is_full, is_empty, last_word, do_push, do_pop, ovf;

  assign rst_now   = hold_rst || (ctl_wr && ctl_wdata[0]);
  assign is_full   = (fill == SLOTS[PW:0]);
  assign is_empty  = (fill == '0);
  assign last_word = ld_en && (word_cnt == 2'd3);
  assign do_push   = last_word && !is_full;
  assign ovf       = last_word && is_full;
  assign do_pop    = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_rst <= 1'b0;
      word_cnt <= '0;
      wp       <= '0;
      rp       <= '0;
      fill     <= '0;
      err      <= 1'b0;
    end else begin
      if (ctl_wr) hold_rst <= ctl_wdata[0];
      if (rst_now) begin
        word_cnt <= '0;
        wp       <= '0;
        rp       <= '0;
        fill     <= '0;
        err      <= 1'b0;
      end else begin
        if (ld_en) word_cnt <= word_cnt + 2'd1;
        if (do_push) wp <= wp + 1'b1;
        if (do_pop)  rp <= rp + 1'b1;
        fill <= fill + {{PW{1'b0}}, do_push} - {{PW{1'b0}}, do_pop};
        if (ovf) err <= 1'b1;
        else if (stat_wr && stat_wdata[10]) err <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_now && ld_en && word_cnt != 2'd3) stage[word_cnt] <= ld_data;
    if (!rst_now && do_push) slot[wp] <= {ld_data, stage[2], stage[1], stage[0]};
  end

  assign out_valid  = !is_empty;
  assign out_addr   = slot[rp][2*WORD_W-1:0];
  assign out_len    = slot[rp][3*WORD_W-1:2*WORD_W];
  assign out_flags  = slot[rp][4*WORD_W-1:3*WORD_W];
  assign out_notify = out_flags[NOTIFY_BIT];

  always_comb begin
    status       = '0;
    status[1:0]  = wp;
    status[5:4]  = rp;
    status[8]    = is_empty;
    status[9]    = is_full;
    status[10]   = err;
  end
endmodule

// File: rtl/desc_ring_chk.sv
module desc_ring_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        stat_wr,
  input logic [31:0] stat_wdata,
  input logic        ctl_wr,
  input logic [31:0] ctl_wdata,
  input logic [31:0] status,
  input logic        out_valid,
  input logic        out_ready
);
  a_r2_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1:0] == status[5:4]) |-> ($countones(status[9:8]) == 1));

  a_r2_flags_need_meet: assert property (@(posedge clk) disable iff (!rst_n)
    (status[9] || status[8]) |-> (status[1:0] == status[5:4]));

  a_r5_valid_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == !status[8]);

  a_r5_pop_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !(ctl_wr && ctl_wdata[0])) |=>
      (status[5:4] == $past(status[5:4]) + 2'd1));

  a_r6_full_wp_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (status[9] && !out_ready && !(ctl_wr && ctl_wdata[0])) |=> $stable(status[1:0]));

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status[10] && !(stat_wr && stat_wdata[10]) && !(ctl_wr && ctl_wdata[0])) |=> status[10]);

  a_r8_reset_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata[0]) |=> (status == 32'h0000_0100));
endmodule

bind desc_ring desc_ring_chk u_chk (.*);

// File: tb/test_desc_ring.sv
module test_desc_ring;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic [31:0] ld_data = '0;
  logic        stat_wr = 1'b0;
  logic [31:0] stat_wdata = '0;
  logic        ctl_wr = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic [31:0] status;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_addr;
  logic [31:0] out_len;
  logic [31:0] out_flags;
  logic        out_notify;

  desc_ring i_desc_ring (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_data(ld_data),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .status(status), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_len(out_len), .out_flags(out_flags), .out_notify(out_notify)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int tagv = 0;

  logic [127:0] m_slot [4];
  int m_wp = 0, m_rp = 0, m_cnt = 0;
  bit m_err = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status();
    logic [31:0] s = '0;
    s[1:0] = m_wp[1:0];
    s[5:4] = m_rp[1:0];
    s[8] = (m_cnt == 0);
    s[9] = (m_cnt == 4);
    s[10] = m_err;
    return s;
  endfunction

  task automatic check_all(input string req);
    logic [31:0] es = exp_status();
    chk(status == es, req, 128'(status), 128'(es));
    chk(out_valid == (m_cnt != 0), {req, "/R5 valid"}, 128'(out_valid), 128'(m_cnt != 0));
    if (m_cnt != 0) begin
      logic [127:0] e = m_slot[m_rp];
      chk({out_flags, out_len, out_addr} == e, {req, "/R3 fields"},
          {out_flags, out_len, out_addr}, e);
      chk(out_notify == e[112], {req, "/R9 notify"}, 128'(out_notify), 128'(e[112]));
    end
  endtask

  task automatic word(input logic [31:0] d);
    ld_en = 1'b1; ld_data = d;
    @(posedge clk); #1;
    ld_en = 1'b0;
  endtask

  task automatic push_desc();
    logic [31:0] lo, hi, ln, fl;
    tagv++;
    lo = 32'h1000_0000 + 32'(tagv * 16);
    hi = 32'(tagv) ^ 32'h0000_5A00;
    ln = 32'h40 * 32'(tagv + 1);
    fl = tagv[0] ? 32'h0001_0000 : 32'h0000_0003;
    word(lo); word(hi); word(ln); word(fl);
    if (m_cnt == 4) m_err = 1'b1;
    else begin
      m_slot[m_wp] = {fl, ln, hi, lo};
      m_wp = (m_wp + 1) % 4;
      m_cnt++;
    end
  endtask

  task automatic pop_desc();
    out_ready = 1'b1;
    @(posedge clk); #1;
    out_ready = 1'b0;
    if (m_cnt > 0) begin
      m_rp = (m_rp + 1) % 4;
      m_cnt--;
    end
  endtask

  task automatic stat_write(input logic [31:0] d);
    stat_wr = 1'b1; stat_wdata = d;
    @(posedge clk); #1;
    stat_wr = 1'b0;
    if (d[10]) m_err = 1'b0;
  endtask

  task automatic ctl_write(input logic [31:0] d);
    ctl_wr = 1'b1; ctl_wdata = d;
    @(posedge clk); #1;
    ctl_wr = 1'b0;
    if (d[0]) begin
      m_wp = 0; m_rp = 0; m_cnt = 0; m_err = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    chk(status == 32'h100, "R1 status", 128'(status), 128'h100);
    chk(out_valid == 1'b0, "R1 valid", 128'(out_valid), 128'h0);

    // R4 partial load commits nothing
    word(32'hAAAA_0001); word(32'hAAAA_0002); word(32'hAAAA_0003);
    chk(status == 32'h100, "R4 partial", 128'(status), 128'h100);
    chk(out_valid == 1'b0, "R4 partial valid", 128'(out_valid), 128'h0);
    word(32'h0001_0000);
    m_slot[0] = {32'h0001_0000, 32'hAAAA_0003, 32'hAAAA_0002, 32'hAAAA_0001};
    m_wp = 1; m_cnt = 1;
    check_all("R4 commit");
    pop_desc();
    check_all("R5 pop one");

    // R10 pop while empty
    pop_desc();
    check_all("R10 pop empty");

    // R2 R3 R5 sweep over occupancies and pointer positions
    for (int round = 0; round < 4; round++) begin
      for (int n = 1; n <= 4; n++) begin
        for (int i = 0; i < n; i++) begin
          push_desc();
          check_all("R2 push");
        end
        if (n == 4) begin
          // R6 overflow keeps contents and pointers
          push_desc();
          check_all("R6 overflow");
          stat_write(32'h0000_0004);
          check_all("R7 clear wrong bit");
          stat_write(32'h0000_0400);
          check_all("R7 clear");
        end
        for (int i = 0; i < n; i++) begin
          pop_desc();
          check_all("R5 drain");
        end
      end
    end

    // R8 ring reset with a partial descriptor pending
    push_desc(); push_desc();
    push_desc(); push_desc(); push_desc();
    check_all("R6 pre-reset err");
    word(32'hDEAD_0001); word(32'hDEAD_0002);
    ctl_write(32'h1);
    check_all("R8 reset held");
    word(32'hBEEF_0001); word(32'hBEEF_0002); word(32'hBEEF_0003); word(32'hBEEF_0004);
    check_all("R8 ignored while held");
    ctl_write(32'h0);
    check_all("R8 released");
    push_desc();
    check_all("R8 fresh descriptor");
    pop_desc();
    check_all("R8 drain");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule